// File: doc/BRIEF.md
# Windowed Register File with Overlapping Frames

This block holds the integer registers of a RISC core that switches register frames on procedure calls. Software sees 32 register numbers. Numbers 0 to 7 always reach one shared global set. Numbers 8 to 31 reach the frame of the active procedure through a current-frame pointer. The physical frames sit in a ring. A frame's outgoing-argument registers are the same storage as the incoming-argument registers of the frame one level deeper, so a caller hands arguments to its callee without copying anything.

A call strobe advances the pointer and a return strobe moves it back. A resident-frame pointer marks the oldest frame still held on chip. When a call would need storage that still belongs to the oldest frame, the block raises an overflow trap. When a return needs a frame that has already been written out, it raises an underflow trap. In both cases the pointer does not move. A trap handler uses the transfer port, which addresses storage by absolute frame number and offset, to copy the incoming-argument and local registers of a frame to memory or back. It then strobes an acknowledge, which moves the resident pointer. The core then reissues the call or return.

Top module: `rwf_regfile`

## Requirements
- R1: After synchronous active-low reset, `cur_win` and `sav_win` are 0, both trap outputs are low, and every register reads 0.
- R2: Register numbers 0–7 select the same storage whatever the value of `cur_win`.
- R3: For frame w, numbers 8–15 select offsets 0–7 of frame w, numbers 16–23 select offsets 8–15 of frame w, and numbers 24–31 select offsets 0–7 of frame (w+1) mod 8. Because of this, numbers 24–31 before a call and numbers 8–15 after the call reach the same storage, and numbers 16–23 are private to each frame.
- R4: With no trap pending, a call alone moves `cur_win` to (w+1) mod 8 and a return alone moves it to (w−1) mod 8, one clock after the strobe. Reads in the next cycle use the new frame. A call and a return in the same cycle change nothing.
- R5: A call raised while (`cur_win`+2) mod 8 equals `sav_win` sets `ovf_trap`, leaves `cur_win` unchanged, and drives `trap_win` with `sav_win`. This is the oldest frame, and the handler saves it.
- R6: An acknowledge while `ovf_trap` is high clears the trap and moves `sav_win` to (`sav_win`+1) mod 8.
- R7: A return raised while `cur_win` equals `sav_win` sets `unf_trap`, leaves `cur_win` unchanged, and drives `trap_win` with (`sav_win`−1) mod 8. This is the frame the handler restores.
- R8: An acknowledge while `unf_trap` is high clears the trap and moves `sav_win` to (`sav_win`−1) mod 8. An acknowledge with no trap pending has no effect.
- R9: While either trap is pending, call and return strobes are ignored and `cur_win` holds.
- R10: A read of the register that the core write port writes in the same cycle returns the new data.
- R11: The transfer port selects storage at 8 + 16·`xfer_win` + `xfer_off`, so offsets 0–7 are a frame's incoming arguments and offsets 8–15 are its locals. It always reads. Its writes take effect only while a trap is pending. If the transfer port and the core write port target the same storage in one cycle, the core write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Core write enable |
| wr_idx | input | 5 | Core write register number |
| wr_data | input | 32 | Core write data |
| call_req | input | 1 | Procedure call strobe |
| ret_req | input | 1 | Procedure return strobe |
| ovf_trap | output | 1 | Overflow trap pending |
| unf_trap | output | 1 | Underflow trap pending |
| cur_win | output | 3 | Current frame pointer |
| sav_win | output | 3 | Oldest resident frame pointer |
| trap_win | output | 3 | Frame the handler must save or restore |
| trap_ack | input | 1 | Handler completion strobe |
| xfer_win | input | 3 | Transfer port absolute frame number |
| xfer_off | input | 4 | Transfer port offset within frame |
| xfer_we | input | 1 | Transfer port write enable |
| xfer_wdata | input | 32 | Transfer port write data |
| xfer_rdata | output | 32 | Transfer port read data |

## Verification
The assertions check the pointer rules on every cycle. These are the one-step movement on a call or a return, raising each trap at the correct pointer relation, holding the pointer while a trap is pending, how each acknowledge moves the resident pointer, and that the two traps are never pending together. Data behaviour can only be shown by the bench's scenarios, which run against a reference model. That covers arguments passing through the shared field, locals staying private, globals surviving frame switches, same-cycle forwarding, transfer writes being refused outside a trap, and a frame spilled and refilled through the transfer port reaching the core again after a return.

// File: rtl/rwf_pkg.sv
// Package: shared types for the windowed register file.
// Assumes: nothing beyond IEEE 1800-2017.
package rwf_pkg;
    typedef enum logic [1:0] {
        WS_RUN = 2'd0,   // no trap pending
        WS_OVF = 2'd1,   // call refused, oldest frame must be saved
        WS_UNF = 2'd2    // return refused, caller frame must be restored
    } wstate_e;
endpackage

// File: rtl/rwf_window_ctl.sv
// Module: frame pointer controller.
// It holds the current frame pointer and the oldest resident frame pointer.
// It decides whether a call or return proceeds or traps, and it retires a trap
// on the handler's acknowledge.
// Assumes: NWIN is a power of two of at least 4, so pointer arithmetic wraps
// naturally in WINW bits.
module rwf_window_ctl #(
    parameter int NWIN = 8,
    localparam int WINW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_req,
    input  logic            ret_req,
    input  logic            trap_ack,
    output logic [WINW-1:0] cwp,
    output logic [WINW-1:0] swp,
    output logic            ovf,
    output logic            unf,
    output logic            pending,
    output logic [WINW-1:0] trap_win
);
    import rwf_pkg::*;

    wstate_e         st_q;
    logic [WINW-1:0] cwp_q;
    logic [WINW-1:0] swp_q;
    logic            ring_full;
    logic            ring_one;
    logic            do_call;
    logic            do_ret;

    // Decode whether a strobe may proceed this cycle.
    always_comb begin
        ring_full = ((cwp_q + WINW'(2)) == swp_q);
        ring_one  = (cwp_q == swp_q);
        do_call   = (st_q == WS_RUN) && call_req && !ret_req;
        do_ret    = (st_q == WS_RUN) && ret_req && !call_req;
    end

    // Advance pointers and trap state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WS_RUN;
            cwp_q <= '0;
            swp_q <= '0;
        end else begin
            case (st_q)
                WS_RUN: begin
                    if (do_call) begin
                        if (ring_full) st_q  <= WS_OVF;
                        else           cwp_q <= cwp_q + WINW'(1);
                    end else if (do_ret) begin
                        if (ring_one)  st_q  <= WS_UNF;
                        else           cwp_q <= cwp_q - WINW'(1);
                    end
                end
                WS_OVF: begin
                    if (trap_ack) begin
                        swp_q <= swp_q + WINW'(1);
                        st_q  <= WS_RUN;
                    end
                end
                WS_UNF: begin
                    if (trap_ack) begin
                        swp_q <= swp_q - WINW'(1);
                        st_q  <= WS_RUN;
                    end
                end
                default: st_q <= WS_RUN;
            endcase
        end
    end

    // Drive status outputs.
    always_comb begin
        cwp      = cwp_q;
        swp      = swp_q;
        ovf      = (st_q == WS_OVF);
        unf      = (st_q == WS_UNF);
        pending  = ovf || unf;
        trap_win = ovf ? swp_q : (swp_q - WINW'(1));
    end
endmodule

// File: rtl/rwf_addr_map.sv
// Module: register number to storage index decoder.
// It concatenates the frame number with the field offset, so no full-width
// address arithmetic is needed beyond a small add.
// Assumes: NGLOB + 3*FIELD register numbers, globals first, then incoming
// arguments, locals and outgoing arguments.
module rwf_addr_map #(
    parameter int NGLOB = 8,
    parameter int FIELD = 8,
    parameter int NWIN  = 8,
    localparam int WINW  = $clog2(NWIN),
    localparam int AW    = $clog2(NGLOB + 3 * FIELD),
    localparam int BLK   = 2 * FIELD,
    localparam int NPHYS = NGLOB + NWIN * BLK,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic [AW-1:0]   arch_idx,
    input  logic [WINW-1:0] win,
    output logic [PW-1:0]   phys_idx
);
    logic [AW-1:0]   off;
    logic [AW-1:0]   fld_off;
    logic [WINW-1:0] blk;

    // Select the global set or the frame block and offset.
    always_comb begin
        off     = arch_idx - AW'(NGLOB);
        blk     = win;
        fld_off = off;
        if (off >= AW'(BLK)) begin
            blk     = win + WINW'(1);
            fld_off = off - AW'(BLK);
        end
        if (arch_idx < AW'(NGLOB))
            phys_idx = PW'(arch_idx);
        else
            phys_idx = PW'(NGLOB) + PW'(blk) * PW'(BLK) + PW'(fld_off);
    end
endmodule

// File: rtl/rwf_storage.sv
// Module: flat register storage with two core reads, one core write and an
// auxiliary read/write pair for the trap handler.
// Core reads forward the core write data of the same cycle. The core write
// takes precedence over the auxiliary write to the same entry.
// Assumes: addresses are already decoded and lie below NPHYS.
module rwf_storage #(
    parameter int DW    = 32,
    parameter int NPHYS = 136,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra_a,
    input  logic [PW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    input  logic          we,
    input  logic [PW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          aux_we,
    input  logic [PW-1:0] aux_a,
    input  logic [DW-1:0] aux_wd,
    output logic [DW-1:0] aux_rd
);
    logic [DW-1:0] mem [NPHYS];

    // Update storage: auxiliary write first, so the core write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else begin
            if (aux_we) mem[aux_a] <= aux_wd;
            if (we)     mem[wa]    <= wd;
        end
    end

    // Core reads with same-cycle forwarding; auxiliary read direct.
    always_comb begin
        rd_a   = (we && (wa == ra_a)) ? wd : mem[ra_a];
        rd_b   = (we && (wa == ra_b)) ? wd : mem[ra_b];
        aux_rd = mem[aux_a];
    end
endmodule

// File: rtl/rwf_regfile.sv
// Module: top of the windowed register file.
// It decodes the core's register numbers through the current frame pointer
// and exposes the trap controls and the handler's transfer port.
// Assumes: a single clock; the handler issues transfer writes only while a
// trap is pending, and writes at other times are dropped.
module rwf_regfile #(
    parameter int DW    = 32,
    parameter int NGLOB = 8,
    parameter int FIELD = 8,
    parameter int NWIN  = 8,
    localparam int WINW  = $clog2(NWIN),
    localparam int AW    = $clog2(NGLOB + 3 * FIELD),
    localparam int BLK   = 2 * FIELD,
    localparam int OW    = $clog2(BLK),
    localparam int NPHYS = NGLOB + NWIN * BLK,
    localparam int PW    = $clog2(NPHYS),
    localparam int NMAP  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic [AW-1:0]   rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            call_req,
    input  logic            ret_req,
    output logic            ovf_trap,
    output logic            unf_trap,
    output logic [WINW-1:0] cur_win,
    output logic [WINW-1:0] sav_win,
    output logic [WINW-1:0] trap_win,
    input  logic            trap_ack,
    input  logic [WINW-1:0] xfer_win,
    input  logic [OW-1:0]   xfer_off,
    input  logic            xfer_we,
    input  logic [DW-1:0]   xfer_wdata,
    output logic [DW-1:0]   xfer_rdata
);
    logic            pending;
    logic [AW-1:0]   map_arch [NMAP];
    logic [PW-1:0]   map_phys [NMAP];
    logic [PW-1:0]   xfer_phys;
    logic            xfer_we_ok;

    rwf_window_ctl #(.NWIN(NWIN)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .call_req (call_req),
        .ret_req  (ret_req),
        .trap_ack (trap_ack),
        .cwp      (cur_win),
        .swp      (sav_win),
        .ovf      (ovf_trap),
        .unf      (unf_trap),
        .pending  (pending),
        .trap_win (trap_win)
    );

    // Gather the core's register numbers: two reads, then the write.
    always_comb begin
        map_arch[0] = rd_a_idx;
        map_arch[1] = rd_b_idx;
        map_arch[2] = wr_idx;
    end

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        rwf_addr_map #(.NGLOB(NGLOB), .FIELD(FIELD), .NWIN(NWIN)) u_map (
            .arch_idx (map_arch[g]),
            .win      (cur_win),
            .phys_idx (map_phys[g])
        );
    end

    // Absolute frame addressing for the handler; writes gated by a trap.
    always_comb begin
        xfer_phys  = PW'(NGLOB) + PW'(xfer_win) * PW'(BLK) + PW'(xfer_off);
        xfer_we_ok = xfer_we && pending;
    end

    rwf_storage #(.DW(DW), .NPHYS(NPHYS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (map_phys[0]),
        .ra_b   (map_phys[1]),
        .rd_a   (rd_a_data),
        .rd_b   (rd_b_data),
        .we     (wr_en),
        .wa     (map_phys[2]),
        .wd     (wr_data),
        .aux_we (xfer_we_ok),
        .aux_a  (xfer_phys),
        .aux_wd (xfer_wdata),
        .aux_rd (xfer_rdata)
    );
endmodule

// File: rtl/rwf_regfile_chk.sv
// Module: property checker for the frame pointer rules, bound to the top.
// Assumes: the pointers are observed at the top-level ports.
module rwf_regfile_chk #(
    parameter int NWIN = 8,
    localparam int WINW = $clog2(NWIN)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            call_req,
    input logic            ret_req,
    input logic            trap_ack,
    input logic            ovf_trap,
    input logic            unf_trap,
    input logic [WINW-1:0] cur_win,
    input logic [WINW-1:0] sav_win
);
    logic quiet;
    assign quiet = !ovf_trap && !unf_trap;

    assert_call_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && call_req && !ret_req && ((cur_win + WINW'(2)) != sav_win))
        |=> (cur_win == ($past(cur_win) + WINW'(1))));

    assert_ret_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ret_req && !call_req && (cur_win != sav_win))
        |=> (cur_win == ($past(cur_win) - WINW'(1))));

    assert_both_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && ret_req) |=> $stable(cur_win));

    assert_no_overflow_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && call_req && !ret_req && ((cur_win + WINW'(2)) == sav_win))
        |=> (ovf_trap && $stable(cur_win)));

    assert_ovf_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trap && trap_ack)
        |=> (!ovf_trap && (sav_win == ($past(sav_win) + WINW'(1)))));

    assert_no_underflow_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && ret_req && !call_req && (cur_win == sav_win))
        |=> (unf_trap && $stable(cur_win)));

    assert_unf_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_trap && trap_ack)
        |=> (!unf_trap && (sav_win == ($past(sav_win) - WINW'(1)))));

    assert_idle_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && trap_ack) |=> $stable(sav_win));

    assert_trap_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!quiet) |=> $stable(cur_win));

    assert_one_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap && unf_trap));
endmodule

bind rwf_regfile rwf_regfile_chk #(.NWIN(NWIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_req),
    .ret_req  (ret_req),
    .trap_ack (trap_ack),
    .ovf_trap (ovf_trap),
    .unf_trap (unf_trap),
    .cur_win  (cur_win),
    .sav_win  (sav_win)
);

// File: tb/rwf_regfile_tb.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a reference model built from the requirements.
module rwf_regfile_tb;
    localparam int NPH = 136;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0, trap_ack = 1'b0;
    logic        ovf_trap, unf_trap;
    logic [2:0]  cur_win, sav_win, trap_win, xfer_win = '0;
    logic [3:0]  xfer_off = '0;
    logic        xfer_we = 1'b0;
    logic [31:0] xfer_wdata = '0, xfer_rdata;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model
    logic [31:0] m_rf [NPH];
    int m_cwp, m_swp, m_st;   // m_st: 0 run, 1 overflow, 2 underflow

    // stimulus for the next cycle
    bit d_call, d_ret, d_we, d_ack, d_xwe;
    int d_widx, d_ra, d_rb, d_xw, d_xo;
    logic [31:0] d_wd, d_xd;

    always #4 clk = ~clk;

    rwf_regfile u_dut (.*);

    function automatic int phys(int idx, int w);
        if (idx < 8) return idx;
        if (idx < 24) return 8 + w * 16 + (idx - 8);
        return 8 + ((w + 1) % 8) * 16 + (idx - 24);
    endfunction

    function automatic logic [31:0] exp_rd(int idx);
        if (d_we && phys(d_widx, m_cwp) == phys(idx, m_cwp)) return d_wd;
        return m_rf[phys(idx, m_cwp)];
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_d();
        d_call = 0; d_ret = 0; d_we = 0; d_ack = 0; d_xwe = 0;
        d_widx = 0; d_ra = 0; d_rb = 0; d_xw = 0; d_xo = 0; d_wd = '0; d_xd = '0;
    endtask

    // Drive the pending stimulus and compare all outputs with the model.
    task automatic tick();
        @(negedge clk);
        call_req = d_call; ret_req = d_ret; wr_en = d_we; trap_ack = d_ack;
        wr_idx = 5'(d_widx); wr_data = d_wd; rd_a_idx = 5'(d_ra); rd_b_idx = 5'(d_rb);
        xfer_we = d_xwe; xfer_win = 3'(d_xw); xfer_off = 4'(d_xo); xfer_wdata = d_xd;
        #1;
        check(rd_a_data, exp_rd(d_ra), "R10 port A model");
        check(rd_b_data, exp_rd(d_rb), "R10 port B model");
        check(32'(cur_win), 32'(m_cwp), "R4 cur_win model");
        check(32'(sav_win), 32'(m_swp), "R6 sav_win model");
        check({31'b0, ovf_trap}, 32'(m_st == 1), "R5 ovf model");
        check({31'b0, unf_trap}, 32'(m_st == 2), "R7 unf model");
        if (m_st != 0)
            check(32'(trap_win), 32'(m_st == 1 ? m_swp : (m_swp + 7) % 8), "R5 trap_win model");
        check(xfer_rdata, m_rf[8 + d_xw * 16 + d_xo], "R11 xfer read model");
    endtask

    // Clock edge: update the model with the stimulus just applied.
    task automatic commit();
        int pre;
        @(posedge clk);
        pre = m_st;
        if (pre != 0 && d_xwe) m_rf[8 + d_xw * 16 + d_xo] = d_xd;
        if (d_we) m_rf[phys(d_widx, m_cwp)] = d_wd;
        if (pre == 0) begin
            if (d_call && !d_ret) begin
                if ((m_cwp + 2) % 8 == m_swp) m_st = 1; else m_cwp = (m_cwp + 1) % 8;
            end else if (d_ret && !d_call) begin
                if (m_cwp == m_swp) m_st = 2; else m_cwp = (m_cwp + 7) % 8;
            end
        end else if (d_ack) begin
            m_swp = (pre == 1) ? (m_swp + 1) % 8 : (m_swp + 7) % 8;
            m_st = 0;
        end
        clear_d();
    endtask

    task automatic cyc();
        tick();
        commit();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NPH; i++) m_rf[i] = '0;
        m_cwp = 0; m_swp = 0; m_st = 0;
        clear_d();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state
        d_ra = 20; d_rb = 31; tick();
        check(32'(cur_win), 0, "R1 cur_win");
        check(32'(sav_win), 0, "R1 sav_win");
        check({30'b0, ovf_trap, unf_trap}, 0, "R1 traps");
        check(rd_a_data, 0, "R1 reg read zero");
        commit();

        // R2: global written in frame 0 seen in frame 1
        d_we = 1; d_widx = 3; d_wd = 32'hA0A0_0003; cyc();
        d_call = 1; cyc();
        d_ra = 3; tick(); check(rd_a_data, 32'hA0A0_0003, "R2 global after call"); commit();

        // R3: outgoing argument in frame 1 becomes incoming argument in frame 2
        d_we = 1; d_widx = 26; d_wd = 32'hB0B0_0026; cyc();
        d_call = 1; cyc();
        d_ra = 10; tick(); check(rd_a_data, 32'hB0B0_0026, "R3 overlap args"); commit();
        d_we = 1; d_widx = 17; d_wd = 32'hC0C0_0017; cyc();
        d_ret = 1; cyc();
        d_ra = 17; d_rb = 26; tick();
        check(rd_a_data, 0, "R3 locals private");
        check(rd_b_data, 32'hB0B0_0026, "R3 caller sees args");
        commit();

        // R4: call and return together do nothing
        d_call = 1; d_ret = 1; cyc();
        tick(); check(32'(cur_win), 1, "R4 both strobes"); commit();

        // R10: same-cycle forwarding
        d_we = 1; d_widx = 9; d_wd = 32'hD0D0_0009; d_ra = 9; tick();
        check(rd_a_data, 32'hD0D0_0009, "R10 bypass"); commit();

        // R11: transfer write outside a trap is dropped
        d_xwe = 1; d_xw = 3; d_xo = 0; d_xd = 32'hFFFF_0000; cyc();
        d_xw = 3; d_xo = 0; tick(); check(xfer_rdata, 0, "R11 write ignored when idle"); commit();

        // R5: fill the ring to overflow
        for (int k = 0; k < 5; k++) begin d_call = 1; cyc(); end
        d_call = 1; cyc();
        tick();
        check({31'b0, ovf_trap}, 1, "R5 overflow raised");
        check(32'(cur_win), 6, "R5 pointer held");
        check(32'(trap_win), 0, "R5 oldest frame");
        commit();
        // R9: call while trapped is ignored
        d_call = 1; cyc();
        tick(); check(32'(cur_win), 6, "R9 call ignored in trap"); commit();
        // R11: handler reads frame 1 and writes frame 0 local
        d_xw = 1; d_xo = 1; tick(); check(xfer_rdata, 32'hD0D0_0009, "R11 xfer read"); commit();
        d_xwe = 1; d_xw = 0; d_xo = 8; d_xd = 32'hE0E0_0008; cyc();
        // R6: acknowledge
        d_ack = 1; cyc();
        tick();
        check({31'b0, ovf_trap}, 0, "R6 trap cleared");
        check(32'(sav_win), 1, "R6 sav_win advanced");
        commit();
        d_call = 1; cyc();
        tick(); check(32'(cur_win), 7, "R6 reissued call"); commit();

        // R7: unwind to underflow
        for (int k = 0; k < 6; k++) begin d_ret = 1; cyc(); end
        d_ret = 1; cyc();
        tick();
        check({31'b0, unf_trap}, 1, "R7 underflow raised");
        check(32'(cur_win), 1, "R7 pointer held");
        check(32'(trap_win), 0, "R7 restore frame");
        commit();
        d_xwe = 1; d_xw = 0; d_xo = 8; d_xd = 32'h1234_5678; cyc();
        // R8: acknowledge and reissue
        d_ack = 1; cyc();
        tick();
        check({31'b0, unf_trap}, 0, "R8 trap cleared");
        check(32'(sav_win), 0, "R8 sav_win retreated");
        commit();
        d_ret = 1; cyc();
        d_ra = 16; tick(); check(rd_a_data, 32'h1234_5678, "R8 refilled local"); commit();
        d_ack = 1; cyc();
        tick(); check(32'(sav_win), 0, "R8 idle ack ignored"); commit();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom % 100);
            d_call = (r < 30) || (r >= 95);
            d_ret  = (r >= 30 && r < 60) || (r >= 95);
            d_we   = ($urandom % 2) == 1;
            d_widx = int'($urandom % 32);
            d_wd   = $urandom;
            d_ra   = int'($urandom % 32);
            d_rb   = (($urandom % 4) == 0) ? d_widx : int'($urandom % 32);
            d_xw   = int'($urandom % 8);
            d_xo   = int'($urandom % 16);
            d_xwe  = ($urandom % 2) == 1;
            d_xd   = $urandom;
            d_ack  = (m_st != 0) ? (($urandom % 6) == 0) : (($urandom % 20) == 0);
            cyc();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule